// File: doc/BRIEF.md
# Asynchronous NOR Flash Access Sequencer

This block sits between a simple internal request port and the pins of an asynchronous NOR flash. The flash has separate address and data pins. Each accepted request becomes one single transfer, either a read or a write. Chip enable, output enable, write enable and the active-low byte lanes are driven through up to four phases in order: address setup, data strobe, data hold and bus turnaround. The length of every phase is a number of system clock cycles.

The phase lengths and an extended-variant selection are presented on a configuration input. The block samples this input together with the request, so each access may use its own timing. A read returns the captured word on `rd_data` together with a one-cycle `done` pulse. A write returns `done` only. After chip enable rises, the requester sees `req_ready` held low for the programmed turnaround gap before the next access can start.

Top module: `nor_async_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of an access, these values hold: `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe`, `busy` and `done` are 0, and `req_ready` is 1.
- R2: Each access starts with an address setup phase of `cfg_setup` cycles (4 bits). In this phase chip enable is low and both output enable and write enable are high. A value of 0 skips the phase.
- R3: The data strobe phase lasts `cfg_strobe` cycles (8 bits), and a value of 0 gives one cycle. During this phase `mem_oe_n` is low for a read or `mem_we_n` is low for a write. The other strobe stays high, and neither strobe is low outside this phase.
- R4: The data hold phase lasts `cfg_hold` cycles for a read. For a write it lasts `cfg_hold`+1 cycles. The exception is the extended variant, which is active only when `cfg_ext` and `cfg_amode` are both 1: there a write hold also lasts `cfg_hold` cycles.
- R5: After `done`, `req_ready` stays low for `cfg_turn` cycles (4 bits). A request held during that gap is accepted only on the first edge after the gap ends.
- R6: A read captures `mem_dq_in` on the last cycle of the strobe phase, while output enable is still low. The captured word is presented on `rd_data` from the `done` cycle onward.
- R7: For a write, `mem_dq_oe` is 1 and `mem_dq_out` equals the request data in every cycle of the setup, strobe and hold phases. For a read, `mem_dq_oe` stays 0.
- R8: `mem_bl_n` is the inverse of `req_be` during a write access and all 0 during a read access. It is all 1 while chip enable is high.
- R9: `busy` is 1 from the cycle after acceptance until chip enable rises. `done` is a single-cycle pulse in the first cycle after the last active phase, and `busy` is 0 in that cycle.
- R10: Configuration inputs are sampled only when a request is accepted. Changing them during an access does not change any phase length of that access.
- R11: `mem_addr` holds the request address, unchanged, throughout the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every phase is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Write byte mask, 1 = lane written |
| req_ready | output | 1 | Idle with turnaround expired; a valid request is taken at this edge |
| cfg_setup | input | 4 | Address setup length |
| cfg_strobe | input | 8 | Data strobe length (0 treated as 1) |
| cfg_hold | input | 4 | Data hold length |
| cfg_turn | input | 4 | Idle gap after chip enable rises |
| cfg_ext | input | 1 | Extended variant request |
| cfg_amode | input | 1 | Access-mode qualifier, required together with cfg_ext |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last captured read word |
| mem_addr | output | ADDR_W | Flash address pins |
| mem_dq_out | output | DATA_W | Data driven to flash |
| mem_dq_oe | output | 1 | Data pin drive enable |
| mem_dq_in | input | DATA_W | Data from flash |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bl_n | output | DATA_W/8 | Byte lane enables, active low |

## Verification
A wrong phase count shows at the pins within the access where it occurs. The number of cycles between chip enable falling and the strobe falling would be wrong, or the strobe width, or the gap before chip enable rises. The bench measures each of these at every access. A wrong write-hold adjustment adds or removes one cycle of hold, and a stale turnaround count shows as `req_ready` returning early or late. Both appear within one access. A capture on the wrong cycle loads the flash model's idle value into `rd_data`, which is visible at the `done` pulse of the same read.

// File: rtl/nor_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared field widths, phase encoding and the timing record
// used by every part of the NOR access sequencer.
package nor_seq_pkg;
    localparam int SETUP_W  = 4;
    localparam int STROBE_W = 8;
    localparam int HOLD_W   = 4;
    localparam int TURN_W   = 4;
    localparam int CNT_W    = STROBE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_TURN
    } phase_e;

    typedef struct packed {
        logic [SETUP_W-1:0]  setup;
        logic [STROBE_W-1:0] strobe;
        logic [HOLD_W-1:0]   hold;
        logic [TURN_W-1:0]   turn;
        logic                ext_en;
        logic                amode;
    } timing_t;
endpackage

// File: rtl/nor_phase_len.sv
`timescale 1ns/1ps
// Module: nor_phase_len
// Converts a timing record and the access direction into the cycle count of
// each phase. Purely combinational.
// Assumes: the extended variant is active only when both ext_en and amode are
// set; a zero strobe field still yields one strobe cycle.
module nor_phase_len
    import nor_seq_pkg::*;
(
    input  timing_t          tim,
    input  logic             is_write,
    output logic [CNT_W-1:0] setup_len,
    output logic [CNT_W-1:0] strobe_len,
    output logic [CNT_W-1:0] hold_len,
    output logic [CNT_W-1:0] turn_len
);
    logic ext_active;
    logic hold_extra;

    // Purpose: decide whether a write receives the extra hold cycle.
    always_comb begin
        ext_active = tim.ext_en & tim.amode;
        hold_extra = is_write & ~ext_active;
    end

    // Purpose: widen the fields to counter width and apply the minimum strobe.
    always_comb begin
        setup_len  = CNT_W'(tim.setup);
        strobe_len = (tim.strobe == '0) ? CNT_W'(1) : CNT_W'(tim.strobe);
        hold_len   = CNT_W'(tim.hold) + CNT_W'(hold_extra);
        turn_len   = CNT_W'(tim.turn);
    end
endmodule

// File: rtl/nor_seq_fsm.sv
`timescale 1ns/1ps
// Module: nor_seq_fsm
// Steps through setup, strobe, hold and turnaround with a single down-counter.
// Phases of zero length are skipped. done is registered and pulses for one
// cycle right after the last active phase.
// Assumes: accept is asserted only while the phase is PH_IDLE; the length
// inputs are already taken from the configuration that belongs to the access.
module nor_seq_fsm
    import nor_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CNT_W-1:0] setup_len,
    input  logic [CNT_W-1:0] strobe_len,
    input  logic [CNT_W-1:0] hold_len,
    input  logic [CNT_W-1:0] turn_len,
    output phase_e           phase,
    output logic             strobe_last,
    output logic             done
);
    phase_e           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             load;
    logic [CNT_W-1:0] load_len;
    logic             last_cycle;
    logic             finish;

    assign last_cycle = (cnt_q == '0);

    // Purpose: choose the next phase and the length to load on entering it.
    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_len = '0;
        finish   = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    load = 1'b1;
                    if (setup_len != '0) begin
                        phase_d  = PH_SETUP;
                        load_len = setup_len;
                    end else begin
                        phase_d  = PH_STROBE;
                        load_len = strobe_len;
                    end
                end
            end
            PH_SETUP: begin
                if (last_cycle) begin
                    phase_d  = PH_STROBE;
                    load     = 1'b1;
                    load_len = strobe_len;
                end
            end
            PH_STROBE: begin
                if (last_cycle) begin
                    if (hold_len != '0) begin
                        phase_d  = PH_HOLD;
                        load     = 1'b1;
                        load_len = hold_len;
                    end else begin
                        finish = 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (last_cycle) finish = 1'b1;
            end
            PH_TURN: begin
                if (last_cycle) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
        if (finish) begin
            if (turn_len != '0) begin
                phase_d  = PH_TURN;
                load     = 1'b1;
                load_len = turn_len;
            end else begin
                phase_d = PH_IDLE;
            end
        end
    end

    // Purpose: next counter value, loaded with length-1 or counting down to 0.
    always_comb begin
        if (load)             cnt_d = load_len - CNT_W'(1);
        else if (!last_cycle) cnt_d = cnt_q - CNT_W'(1);
        else                  cnt_d = cnt_q;
    end

    // Purpose: phase, counter and done pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            done    <= finish;
        end
    end

    assign phase       = phase_q;
    assign strobe_last = (phase_q == PH_STROBE) && last_cycle;
endmodule

// File: rtl/nor_pin_drive.sv
`timescale 1ns/1ps
// Module: nor_pin_drive
// Holds the accepted request and drives the flash pins from the current phase.
// Captures read data on the final strobe cycle.
// Assumes: phase comes from a register, so the pin decode has one level of
// logic; bus lanes are bytes.
module nor_pin_drive
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  phase_e            phase,
    input  logic              strobe_last,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              wr_q,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [BE_W-1:0]   mem_bl_n
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BE_W-1:0]   be_q;
    logic              active;
    logic              strobe;

    // Purpose: hold the request fields for the duration of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Purpose: sample the flash data bus on the final read strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_data <= '0;
        else if (strobe_last && !wr_q) rd_data <= mem_dq_in;
    end

    // Purpose: decode the registered phase into the active-low pin controls.
    always_comb begin
        active     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobe     = (phase == PH_STROBE);
        mem_ce_n   = ~active;
        mem_oe_n   = ~(strobe & ~wr_q);
        mem_we_n   = ~(strobe & wr_q);
        mem_dq_oe  = active & wr_q;
        mem_addr   = addr_q;
        mem_dq_out = wdata_q;
    end

    // Purpose: per-lane enables, following the mask only for write accesses.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        always_comb begin
            mem_bl_n[g] = active ? ~(be_q[g] | ~wr_q) : 1'b1;
        end
    end
endmodule

// File: rtl/nor_async_seq.sv
`timescale 1ns/1ps
// Module: nor_async_seq (top)
// Turns single read or write requests into timed asynchronous NOR flash
// cycles. The configuration is sampled at acceptance.
// Assumes: non-multiplexed address and data pins; no wait input and no burst.
// A request is taken only when req_ready is high.
module nor_async_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [BE_W-1:0]     req_be,
    output logic                req_ready,
    input  logic [SETUP_W-1:0]  cfg_setup,
    input  logic [STROBE_W-1:0] cfg_strobe,
    input  logic [HOLD_W-1:0]   cfg_hold,
    input  logic [TURN_W-1:0]   cfg_turn,
    input  logic                cfg_ext,
    input  logic                cfg_amode,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [BE_W-1:0]     mem_bl_n
);
    timing_t          tim_in, tim_q, tim_eff;
    phase_e           phase;
    logic             accept;
    logic             wr_q, wr_eff;
    logic             strobe_last;
    logic [CNT_W-1:0] setup_len, strobe_len, hold_len, turn_len;

    // Purpose: gather the configuration inputs into one record.
    always_comb begin
        tim_in.setup  = cfg_setup;
        tim_in.strobe = cfg_strobe;
        tim_in.hold   = cfg_hold;
        tim_in.turn   = cfg_turn;
        tim_in.ext_en = cfg_ext;
        tim_in.amode  = cfg_amode;
    end

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid & req_ready;
    assign busy      = ~mem_ce_n;
    assign tim_eff   = accept ? tim_in : tim_q;
    assign wr_eff    = accept ? req_write : wr_q;

    // Purpose: keep the configuration of the access in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)      tim_q <= '0;
        else if (accept) tim_q <= tim_in;
    end

    nor_phase_len u_len (
        .tim        (tim_eff),
        .is_write   (wr_eff),
        .setup_len  (setup_len),
        .strobe_len (strobe_len),
        .hold_len   (hold_len),
        .turn_len   (turn_len)
    );

    nor_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .setup_len   (setup_len),
        .strobe_len  (strobe_len),
        .hold_len    (hold_len),
        .turn_len    (turn_len),
        .phase       (phase),
        .strobe_last (strobe_last),
        .done        (done)
    );

    nor_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .phase       (phase),
        .strobe_last (strobe_last),
        .mem_dq_in   (mem_dq_in),
        .wr_q        (wr_q),
        .rd_data     (rd_data),
        .mem_addr    (mem_addr),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe),
        .mem_ce_n    (mem_ce_n),
        .mem_oe_n    (mem_oe_n),
        .mem_we_n    (mem_we_n),
        .mem_bl_n    (mem_bl_n)
    );
endmodule

// File: rtl/nor_async_seq_chk.sv
`timescale 1ns/1ps
// Module: nor_async_seq_chk
// Protocol checker attached to nor_async_seq through bind. It observes only
// the ports of the top module.
module nor_async_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int BE_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [BE_W-1:0]   mem_bl_n
);
    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_oe_within_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> !mem_ce_n);

    assert_drive_within_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_ce_n);

    assert_lanes_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (&mem_bl_n));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_ready_only_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !busy));

    assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind nor_async_seq nor_async_seq_chk #(
    .ADDR_W (ADDR_W),
    .BE_W   (BE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_bl_n  (mem_bl_n)
);

// File: tb/nor_async_seq_tb.sv
`timescale 1ns/1ps
// Bench for nor_async_seq: a vector table walked by one loop, then directed
// tests for reset, the turnaround gap and configuration changes mid-access.
module nor_async_seq_tb;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] req_be = '0;
    logic          req_ready;
    logic [3:0]    cfg_setup = '0, cfg_hold = '0, cfg_turn = '0;
    logic [7:0]    cfg_strobe = '0;
    logic          cfg_ext = 1'b0, cfg_amode = 1'b0;
    logic          busy, done;
    logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;
    logic          mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
    logic [BW-1:0] mem_bl_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Flash model: a word derived from the address while output enable is low.
    assign mem_dq_in = mem_oe_n ? 16'h0BAD : (mem_addr ^ 16'h5A5A);

    nor_async_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
        .cfg_hold(cfg_hold), .cfg_turn(cfg_turn), .cfg_ext(cfg_ext),
        .cfg_amode(cfg_amode), .busy(busy), .done(done), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_bl_n(mem_bl_n)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // {wr, ext, amode, setup[4], strobe[8], hold[4], turn[4], be[2], addr[16], wdata[16]}
    localparam int NV = 8;
    localparam logic [56:0] VECS [NV] = '{
        {1'b0, 1'b0, 1'b0, 4'd2,  8'd3,  4'd1,  4'd2,  2'b11, 16'h1234, 16'h0000},
        {1'b1, 1'b0, 1'b0, 4'd2,  8'd3,  4'd1,  4'd2,  2'b11, 16'h2000, 16'hC0DE},
        {1'b0, 1'b0, 1'b0, 4'd0,  8'd1,  4'd0,  4'd0,  2'b00, 16'h0F0F, 16'h0000},
        {1'b1, 1'b0, 1'b0, 4'd0,  8'd0,  4'd0,  4'd0,  2'b10, 16'h0042, 16'hBEEF},
        {1'b1, 1'b1, 1'b1, 4'd1,  8'd2,  4'd0,  4'd3,  2'b11, 16'h7777, 16'h1111},
        {1'b1, 1'b1, 1'b0, 4'd1,  8'd2,  4'd0,  4'd1,  2'b01, 16'h8001, 16'h2222},
        {1'b0, 1'b1, 1'b1, 4'd15, 8'd20, 4'd15, 4'd15, 2'b00, 16'hFFFF, 16'h0000},
        {1'b1, 1'b0, 1'b0, 4'd3,  8'd4,  4'd2,  4'd1,  2'b01, 16'h00A5, 16'h5AA5}
    };

    // Runs one access and measures every phase at the pins.
    task automatic run_access(input logic [56:0] v, input bit scramble);
        logic wr, ext, am;
        logic [3:0] st, hd, tn;
        logic [7:0] sb;
        logic [1:0] be;
        logic [15:0] ad, wd;
        int es, ed, eh, et, ns, nd, nh, nt;
        int bad_ce, bad_ad, bad_dq, bad_bl, bad_dn;
        bit rdy_at_done;
        {wr, ext, am, st, sb, hd, tn, be, ad, wd} = v;
        es = int'(st);
        ed = (sb == 0) ? 1 : int'(sb);
        eh = int'(hd) + ((wr && !(ext && am)) ? 1 : 0);
        et = int'(tn);
        ns = 0; nd = 0; nh = 0;
        bad_ce = 0; bad_ad = 0; bad_dq = 0; bad_bl = 0; bad_dn = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = wd; req_be = be;
        cfg_setup = st; cfg_strobe = sb; cfg_hold = hd; cfg_turn = tn;
        cfg_ext = ext; cfg_amode = am;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = ~ad; req_wdata = ~wd; req_be = ~be;
        if (scramble) begin
            cfg_setup = 4'd9; cfg_strobe = 8'd9; cfg_hold = 4'd9; cfg_turn = 4'd9;
            cfg_ext = ~ext; cfg_amode = ~am;
        end
        check("R9 busy after accept", busy, 1);
        while (busy) begin
            if (mem_ce_n !== 1'b0) bad_ce++;
            if (wr ? (mem_oe_n !== 1'b1) : (mem_we_n !== 1'b1)) bad_ce++;
            if (mem_addr !== ad) bad_ad++;
            if (wr ? (mem_dq_oe !== 1'b1 || mem_dq_out !== wd) : (mem_dq_oe !== 1'b0)) bad_dq++;
            if (mem_bl_n !== (wr ? ~be : 2'b00)) bad_bl++;
            if (done) bad_dn++;
            if (wr ? !mem_we_n : !mem_oe_n) nd++;
            else if (nd == 0) ns++;
            else nh++;
            @(negedge clk);
        end
        check("R2 setup cycles", ns, es);
        check("R3 strobe cycles", nd, ed);
        check("R4 hold cycles", nh, eh);
        check("R3 wrong strobe or ce during access", bad_ce, 0);
        check("R11 address changed", bad_ad, 0);
        check("R7 data drive", bad_dq, 0);
        check("R8 byte lanes", bad_bl, 0);
        check("R9 done during busy", bad_dn, 0);
        check("R9 done at end", done, 1);
        check("R8 lanes idle", mem_bl_n, 2'b11);
        if (!wr) check("R6 read data", rd_data, ad ^ 16'h5A5A);
        rdy_at_done = req_ready;
        @(negedge clk);
        check("R9 done single cycle", done, 0);
        nt = rdy_at_done ? 0 : 1;
        while (!req_ready) begin
            nt++;
            @(negedge clk);
        end
        check(scramble ? "R10 turnaround unaffected" : "R5 turnaround cycles", nt, et);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ce_n", mem_ce_n, 1);
        check("R1 oe_n", mem_oe_n, 1);
        check("R1 we_n", mem_we_n, 1);
        check("R1 dq_oe", mem_dq_oe, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_access(VECS[i], 1'b0);

        // R10: configuration changed right after acceptance
        run_access({1'b0, 1'b0, 1'b0, 4'd2, 8'd3, 4'd1, 4'd1, 2'b11, 16'h3C3C, 16'h0}, 1'b1);
        run_access({1'b1, 1'b1, 1'b1, 4'd1, 8'd5, 4'd2, 4'd2, 2'b10, 16'h4444, 16'h9999}, 1'b1);

        // R5: a request held through the turnaround is taken right after it
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0101;
        cfg_setup = 4'd1; cfg_strobe = 8'd1; cfg_hold = 4'd0; cfg_turn = 4'd4;
        cfg_ext = 1'b0; cfg_amode = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        req_valid = 1'b1;
        n = 0;
        while (!busy) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        check("R5 held request start delay", n, 5);
        while (!req_ready) @(negedge clk);

        // R1: reset in the middle of an access
        req_valid = 1'b1; req_write = 1'b1; req_wdata = 16'hAAAA; req_be = 2'b11;
        cfg_setup = 4'd4; cfg_strobe = 8'd4; cfg_hold = 4'd1; cfg_turn = 4'd3;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 busy before mid reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset ce_n", mem_ce_n, 1);
        check("R1 mid reset we_n", mem_we_n, 1);
        check("R1 mid reset dq_oe", mem_dq_oe, 0);
        check("R1 mid reset busy", busy, 0);
        check("R1 mid reset ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule